// File: doc/BRIEF.md
# CRC Accelerator

A CRC engine with a programmable 32-bit reduction polynomial and a readable, seedable residue. Input arrives on a valid/ready stream at one of three sizes: a full word, a single byte, or a partial byte of one to eight bits. A word can be reordered before it is folded in, by swapping its 16-bit halves, reversing its byte order and reversing the bits inside each byte. The update runs either MSB-first with a left shift, or LSB-first with a right shift on a reflected polynomial.

Configuration goes through a plain register port with a single-cycle write and a combinational read. Writing the signature register compares the written value with the current residue. A mismatch sets a sticky error flag, and that flag drives the interrupt only when the interrupt enable is set.

The stream rules are these. `in_ready` is high only while the engine is enabled and no residue write is present in the same cycle. A beat transfers on a rising edge where `in_valid` and `in_ready` are both high. A producer that holds `in_valid` keeps its beat pending with no loss. An enabled engine accepts one beat every cycle.

Top module: `crc_accel`

## Requirements
- R1: After reset the register reads are: control (address 0) 0, polynomial (address 1) 0x04C11DB7, residue (address 2) 0xFFFFFFFF, signature (address 3) 0, error status (address 4) 0 and interrupt enable (address 5) 0. `crc_irq` is low.
- R2: Control bit 0 enables the engine. With bit 4 clear, an accepted word (`in_size`=0) is folded in MSB-first, starting at data bit 31. Each bit b applies: feedback = residue[31]^b, residue = (residue<<1) ^ (feedback ? poly : 0). The new residue is readable from the cycle after the accepting edge.
- R3: With control bit 4 set, the update runs LSB-first, starting at data bit 0. Each bit applies: feedback = residue[0]^b, residue = (residue>>1) ^ (feedback ? poly : 0).
- R4: A byte beat (`in_size`=1) folds in only `in_data[7:0]`: bit 7 first in MSB-first mode, bit 0 first in LSB-first mode.
- R5: Writing address 2 loads the residue with the written value. In that cycle `in_ready` is low, so no beat is folded in.
- R6: While control bit 0 is clear, `in_ready` is low and the residue changes only through a write to address 2.
- R7: A partial beat (`in_size`=2) folds in the low `in_len`+1 bits of `in_data`. Bit `in_len` goes first in MSB-first mode and bit 0 goes first in LSB-first mode.
- R8: A word is reordered before the update in a fixed order. Control bit 1 swaps the 16-bit halves. Control bit 2 then reverses the byte order. Control bit 3 then reverses the bits within each byte. Bit 3 also reverses a byte beat. Partial beats are never reordered.
- R9: Writing address 3 stores the value and compares it with the residue held before that edge. A mismatch sets error status bit 0, and a match leaves the bit unchanged. The bit stays set until a write to address 4 with bit 0 at 1.
- R10: `crc_irq` is high exactly when error status bit 0 and interrupt enable bit 0 (address 5) are both set.
- R11: While enabled, beats are accepted on consecutive cycles. Each accepted beat is folded in on top of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_data | input | 32 | Input beat data |
| in_size | input | 2 | 0 word, 1 byte, 2 partial byte |
| in_len | input | 3 | Partial beat bit count minus one |
| crc_irq | output | 1 | Signature-mismatch interrupt |

## Verification
A wrong polynomial step, a wrong reordering stage or a wrong alignment of a partial beat shows up in the residue one cycle after the beat is accepted. Every configuration of reordering and bit order is swept over all three input sizes and all eight partial lengths, and the residue is read back after every beat. A fault in flag handling shows on `crc_irq` and on the status read in the cycle after the signature or clear write. A fault in stream handling shows on `in_ready` in the same cycle, or as a beat that is lost or folded in twice.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_PART = 2'd2,
    SZ_RSVD = 2'd3
  } in_size_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_POLY = 3'd1;
  localparam logic [2:0] A_RES  = 3'd2;
  localparam logic [2:0] A_SIG  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_IEN  = 3'd5;

  // bit 0 enable .. bit 4 lsb_first
  typedef struct packed {
    logic lsb_first;
    logic bit_mirror;
    logic byte_rev;
    logic swap16;
    logic enable;
  } ctrl_t;

endpackage

// File: rtl/crc_input_align.sv
module crc_input_align
  import crc_acc_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_data,
  input  logic [1:0]    in_size,
  input  logic [2:0]    in_len,
  input  ctrl_t         ctrl,
  output logic [W-1:0]  stream,
  output logic [CW-1:0] nbits
);
  localparam int NB = W / 8;
  localparam int H  = W / 2;

  logic [W-1:0] swapped, byte_swapped, word_final;
  logic [7:0]   byte_val;

  assign swapped = ctrl.swap16 ? {in_data[H-1:0], in_data[W-1:H]} : in_data;

  // Stage order: halves swap, then byte order, then bits inside each byte.
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign byte_swapped[8*k +: 8] = ctrl.byte_rev ? swapped[8*(NB-1-k) +: 8]
                                                   : swapped[8*k +: 8];
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign word_final[8*k + j] = ctrl.bit_mirror ? byte_swapped[8*k + 7 - j]
                                                   : byte_swapped[8*k + j];
    end
  end

  for (genvar j = 0; j < 8; j++) begin : g_bytebit
    assign byte_val[j] = ctrl.bit_mirror ? in_data[7 - j] : in_data[j];
  end

  // First bit to fold sits at W-1 (MSB-first) or at 0 (LSB-first).
  always_comb begin
    unique case (in_size_e'(in_size))
      SZ_BYTE: begin
        stream = ctrl.lsb_first ? {{(W-8){1'b0}}, byte_val}
                                : {byte_val, {(W-8){1'b0}}};
        nbits  = CW'(8);
      end
      SZ_PART: begin
        stream = ctrl.lsb_first ? {{(W-8){1'b0}}, in_data[7:0]}
                                : ({in_data[7:0], {(W-8){1'b0}}} << (3'd7 - in_len));
        nbits  = CW'(in_len) + CW'(1);
      end
      default: begin
        stream = word_final;
        nbits  = CW'(W);
      end
    endcase
  end
endmodule

// File: rtl/crc_unrolled_update.sv
module crc_unrolled_update #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  seed,
  input  logic [W-1:0]  poly,
  input  logic [W-1:0]  stream,
  input  logic [CW-1:0] nbits,
  input  logic          lsb_first,
  output logic [W-1:0]  result
);
  logic [W-1:0] acc;
  logic         fb, din;

  always_comb begin
    acc = seed;
    fb  = 1'b0;
    din = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(nbits)) begin
        if (lsb_first) begin
          din = stream[i];
          fb  = acc[0] ^ din;
          acc = (acc >> 1) ^ (fb ? poly : '0);
        end else begin
          din = stream[W-1-i];
          fb  = acc[W-1] ^ din;
          acc = {acc[W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
      end
    end
    result = acc;
  end
endmodule

// File: rtl/crc_sig_check.sv
module crc_sig_check #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sig_we,
  input  logic [W-1:0] sig_wdata,
  input  logic [W-1:0] residue,
  input  logic         clr_we,
  input  logic         clr_bit,
  input  logic         irq_en,
  output logic [W-1:0] sig_q,
  output logic         err_q,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (sig_we) begin
        sig_q <= sig_wdata;
        if (sig_wdata != residue) err_q <= 1'b1;
      end else if (clr_we && clr_bit) begin
        err_q <= 1'b0;
      end
    end
  end

  assign irq = err_q & irq_en;

  a_r9_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_we && sig_wdata != residue) |=> err_q);
  a_r9_match_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_we && sig_wdata == residue && !err_q) |=> !err_q);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(clr_we && clr_bit)) |=> err_q);
endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_acc_pkg::*;
#(
  parameter int          W         = 32,
  parameter logic [31:0] POLY_INIT = 32'h04C1_1DB7,
  parameter logic [31:0] RES_INIT  = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic [2:0]   cfg_raddr,
  output logic [W-1:0] cfg_rdata,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [1:0]   in_size,
  input  logic [2:0]   in_len,
  output logic         crc_irq
);
  localparam int CW     = $clog2(W + 1);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t        ctrl_q;
  logic [W-1:0] poly_q, res_q, sig_q, stream, res_next;
  logic [CW-1:0] nbits;
  logic         ien_q, err_q, res_wr, accept;

  assign res_wr   = cfg_we && (cfg_addr == A_RES);
  assign in_ready = ctrl_q.enable && !res_wr;
  assign accept   = in_valid && in_ready;

  crc_input_align #(.W(W), .CW(CW)) u_align (
    .in_data (in_data),
    .in_size (in_size),
    .in_len  (in_len),
    .ctrl    (ctrl_q),
    .stream  (stream),
    .nbits   (nbits)
  );

  crc_unrolled_update #(.W(W), .CW(CW)) u_update (
    .seed      (res_q),
    .poly      (poly_q),
    .stream    (stream),
    .nbits     (nbits),
    .lsb_first (ctrl_q.lsb_first),
    .result    (res_next)
  );

  crc_sig_check #(.W(W)) u_sig (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_we    (cfg_we && (cfg_addr == A_SIG)),
    .sig_wdata (cfg_wdata),
    .residue   (res_q),
    .clr_we    (cfg_we && (cfg_addr == A_STAT)),
    .clr_bit   (cfg_wdata[0]),
    .irq_en    (ien_q),
    .sig_q     (sig_q),
    .err_q     (err_q),
    .irq       (crc_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      poly_q <= W'(POLY_INIT);
      res_q  <= W'(RES_INIT);
      ien_q  <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_CTRL) ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      if (cfg_we && cfg_addr == A_POLY) poly_q <= cfg_wdata;
      if (cfg_we && cfg_addr == A_IEN)  ien_q  <= cfg_wdata[0];
      if (res_wr)      res_q <= cfg_wdata;
      else if (accept) res_q <= res_next;
    end
  end

  always_comb begin
    unique case (cfg_raddr)
      A_CTRL:  cfg_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
      A_POLY:  cfg_rdata = poly_q;
      A_RES:   cfg_rdata = res_q;
      A_SIG:   cfg_rdata = sig_q;
      A_STAT:  cfg_rdata = {{(W-1){1'b0}}, err_q};
      A_IEN:   cfg_rdata = {{(W-1){1'b0}}, ien_q};
      default: cfg_rdata = '0;
    endcase
  end

  a_r5_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> (res_q == $past(cfg_wdata)));
  a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.enable && !res_wr) |=> $stable(res_q));
  a_r11_ready_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.enable && !cfg_we) |-> in_ready);
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    crc_irq |-> (err_q && ien_q));
endmodule

// File: tb/tb_crc_accel.sv
module tb_crc_accel;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0, cfg_raddr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_len = '0;
  logic        crc_irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  crc_accel dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_bit(logic [31:0] c, logic b, logic lsb, logic [31:0] p);
    if (lsb) return (c[0] ^ b) ? ((c >> 1) ^ p) : (c >> 1);
    return (c[31] ^ b) ? ({c[30:0], 1'b0} ^ p) : {c[30:0], 1'b0};
  endfunction

  // ctl: [0] swap16 [1] byte reverse [2] bit mirror [3] lsb first
  function automatic logic [31:0] m_feed(logic [31:0] c, logic [31:0] d, int sz, int len,
                                         logic [3:0] ctl, logic [31:0] p);
    logic [31:0] w, v;
    logic [7:0] b8;
    int n;
    if (sz == 0) begin
      w = ctl[0] ? {d[15:0], d[31:16]} : d;
      if (ctl[1]) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
      v = w;
      if (ctl[2]) for (int k = 0; k < 32; k++) v[k] = w[(k/8)*8 + 7 - (k%8)];
      n = 32;
    end else if (sz == 1) begin
      b8 = d[7:0];
      if (ctl[2]) for (int k = 0; k < 8; k++) b8[k] = d[7-k];
      v = {24'b0, b8};
      n = 8;
    end else begin
      v = d;
      n = len + 1;
    end
    for (int i = 0; i < n; i++)
      c = m_bit(c, ctl[3] ? v[i] : v[n-1-i], ctl[3], p);
    return c;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_raddr = a; #1; d = cfg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input int sz, input int len);
    in_valid = 1'b1; in_data = d; in_size = 2'(sz); in_len = 3'(len);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, model, pl, seed;
    logic [31:0] pats [3];
    string tag;
    pats[0] = 32'h1234_5678; pats[1] = 32'hA5C3_0F96; pats[2] = 32'h8000_0001;
    @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R1 reset values
    rd(3'd0, r); check("R1 ctrl", r, 32'h0);
    rd(3'd1, r); check("R1 poly", r, 32'h04C11DB7);
    rd(3'd2, r); check("R1 residue", r, 32'hFFFFFFFF);
    rd(3'd3, r); check("R1 sig", r, 32'h0);
    rd(3'd4, r); check("R1 status", r, 32'h0);
    rd(3'd5, r); check("R1 ien", r, 32'h0);
    check("R1 irq", {31'b0, crc_irq}, 32'h0);

    // R6 disabled: ready low, residue held
    in_valid = 1'b1; in_data = 32'hDEADBEEF; in_size = 2'd0;
    #1; check("R6 ready low", {31'b0, in_ready}, 32'h0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rd(3'd2, r); check("R6 residue held", r, 32'hFFFFFFFF);

    // R5 seed readback
    wr(3'd2, 32'h1357_9BDF); rd(3'd2, r); check("R5 seed", r, 32'h13579BDF);

    // Sweep of order, reordering, size and partial length (R2 R3 R4 R7 R8)
    for (int c = 0; c < 16; c++) begin
      pl = c[3] ? 32'hEDB88320 : 32'h04C11DB7;
      wr(3'd1, pl);
      wr(3'd0, {27'b0, c[3:0], 1'b1});
      for (int p = 0; p < 3; p++) begin
        for (int sz = 0; sz < 3; sz++) begin
          for (int len = 0; len < ((sz == 2) ? 8 : 1); len++) begin
            seed = pats[(p + 1) % 3] ^ (32'h0101_0101 * c) ^ len;
            wr(3'd2, seed);
            push(pats[p], sz, len);
            model = m_feed(seed, pats[p], sz, len, c[3:0], pl);
            rd(3'd2, r);
            if (sz == 2) tag = "R7 partial";
            else if (sz == 1) tag = "R4 byte";
            else if (c[2:0] != 0) tag = "R8 reorder";
            else if (c[3]) tag = "R3 lsb word";
            else tag = "R2 msb word";
            check(tag, r, model);
          end
        end
      end
    end

    // R11 back-to-back beats, MSB-first plain
    wr(3'd1, 32'h04C11DB7); wr(3'd0, 32'h1);
    wr(3'd2, 32'hFFFFFFFF); model = 32'hFFFFFFFF;
    in_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      in_data = 32'h0F0F_0000 + k * 32'h1111; in_size = 2'd0;
      #1; check("R11 ready each cycle", {31'b0, in_ready}, 32'h1);
      model = m_feed(model, in_data, 0, 0, 4'h0, 32'h04C11DB7);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    rd(3'd2, r); check("R11 streamed residue", r, model);

    // R5 residue write blocks the beat of the same cycle
    in_valid = 1'b1; in_data = 32'h55AA55AA; in_size = 2'd0;
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'h0000_0001;
    #1; check("R5 ready low on seed", {31'b0, in_ready}, 32'h0);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    rd(3'd2, r); check("R5 seed wins", r, 32'h1);

    // R9 / R10 signature compare and interrupt
    wr(3'd3, 32'h1); rd(3'd4, r); check("R9 match no error", r, 32'h0);
    rd(3'd3, r); check("R9 sig stored", r, 32'h1);
    wr(3'd3, 32'h2); rd(3'd4, r); check("R9 mismatch sets", r, 32'h1);
    check("R10 masked irq", {31'b0, crc_irq}, 32'h0);
    wr(3'd5, 32'h1); check("R10 irq raised", {31'b0, crc_irq}, 32'h1);
    wr(3'd3, 32'h1); rd(3'd4, r); check("R9 match keeps flag", r, 32'h1);
    wr(3'd4, 32'h0); rd(3'd4, r); check("R9 write 0 no clear", r, 32'h1);
    wr(3'd4, 32'h1); rd(3'd4, r); check("R9 w1c", r, 32'h0);
    check("R10 irq drops", {31'b0, crc_irq}, 32'h0);

    // R6 disable after use keeps residue
    wr(3'd0, 32'h0);
    in_valid = 1'b1; in_data = 32'h1; repeat (2) @(negedge clk); in_valid = 1'b0;
    rd(3'd2, r); check("R6 held after disable", r, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule